// File: doc/BRIEF.md
# Three-Phase Bridge Output Level Register

This block holds the fixed drive levels for the six pins of a three-phase bridge (U, U-bar, V, V-bar, W, W-bar) for the times when those pins are in level-output state. Software writes a staging buffer over a small register bus. A separate active register drives the pins. The active register copies the buffer only when a load event occurs, so a new pattern written by software takes effect at a chosen instant rather than part-way through a PWM period.

A control register selects the load event. It is either a one-cycle compare-match pulse from an external timer or a software load strobe. A second control bit turns on complementary mode: each lower-side pin then drives the inverse of its upper-side bit, and the lower-side buffer bits are ignored. When the PWM counter is reported halted, a buffer write also lands in the active register in the same cycle.

Each pin has its own level-output enable. When an enable is low, that pin carries the external PWM waveform instead of the register level. The bus has no wait states and no back-pressure. A write is taken on every clock in which `bus_wr` is high, and read data is valid in the same cycle that `bus_addr` is presented.

Top module: `tpo_level_reg`

## Requirements
- R1: Active register bit i (bit 0 U, 1 U-bar, 2 V, 3 V-bar, 4 W, 5 W-bar) drives `pin_o[i]`, where 1 means high and 0 means low, when `lvl_en_i[i]` is 1 and complementary mode is off.
- R2: A buffer write (address 0) with `cnt_halted_i` low does not change the pins until a load event occurs.
- R3: With the select bit (control address 1, bit 0) at 0, a `cmp_match_i` pulse copies the buffer into the active register, and the pins show the new value in the next cycle.
- R4: With the select bit at 1, a control write with bit 2 set copies the buffer into the active register, and `cmp_match_i` is ignored. With the select bit at 0, the software strobe has no effect. Control bit 2 always reads back as 0.
- R5: With complementary mode on (control bit 1), pins 1, 3 and 5 drive the inverse of active bits 0, 2 and 4, and active bits 1, 3 and 5 have no effect.
- R6: While `cnt_halted_i` is high, a buffer write updates both the buffer and the active register at the same clock edge.
- R7: Writes to buffer bits 7:6 have no effect, and those bits always read back as 1.
- R8: After reset, the buffer reads 0xC0, the control register reads 0x00, and all pins that have level-output enable high are low.
- R9: If a buffer write and a load event occur in the same cycle, the active register takes the newly written value.
- R10: A pin whose `lvl_en_i` bit is 0 drives the matching `pwm_wave_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, the OR of all reset sources |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register address: 0 buffer, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_match_i | input | 1 | Compare-match pulse from the timer |
| cnt_halted_i | input | 1 | High while the PWM counter is stopped |
| lvl_en_i | input | 6 | Per-pin level-output enable |
| pwm_wave_i | input | 6 | Per-pin PWM waveform used when the enable is low |
| pin_o | output | 6 | Bridge pin drive |

## Verification
The active register can only be observed through the pins. A load that is wrongly taken or wrongly missed therefore shows at `pin_o` one cycle after the triggering edge, provided that the level enables are high. The bench keeps those enables high for most of the run. Errors in the buffer or the control bits appear at once on a read. They also appear at the pins after the next load or write-through. Because of this, every stimulus step is followed by both a read and a pin comparison. A reference model compares the pins and the read data on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int ADDR_BUF = 0;
  localparam int ADDR_CTL = 1;
  localparam int CTL_SRC  = 0;  // 0: compare-match load, 1: software load
  localparam int CTL_COMP = 1;  // complementary mode
  localparam int CTL_SWLD = 2;  // software load strobe, write-only

  typedef struct packed {
    logic comp;
    logic src_sw;
  } ctl_t;
endpackage

// File: rtl/tpo_bus_regs.sv
module tpo_bus_regs
  import tpo_pkg::*;
#(
  parameter int NPIN = 6,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NPIN-1:0] buf_q,
  output ctl_t            ctl_q,
  output logic            wr_buf,
  output logic            sw_strobe
);
  localparam int PAD = DW - NPIN;

  logic sel_buf, sel_ctl;
  logic unused_wbits;

  assign sel_buf = (bus_addr == AW'(ADDR_BUF));
  assign sel_ctl = (bus_addr == AW'(ADDR_CTL));
  assign wr_buf  = bus_wr && sel_buf;
  // Load strobe honoured only when software load is already selected
  assign sw_strobe = bus_wr && sel_ctl && bus_wdata[CTL_SWLD] && ctl_q.src_sw;
  assign unused_wbits = ^bus_wdata[DW-1:NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_buf) buf_q <= bus_wdata[NPIN-1:0];
      if (bus_wr && sel_ctl) begin
        ctl_q.src_sw <= bus_wdata[CTL_SRC];
        ctl_q.comp   <= bus_wdata[CTL_COMP];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_buf) begin
      bus_rdata = {{PAD{1'b1}}, buf_q};
    end else if (sel_ctl) begin
      bus_rdata[CTL_SRC]  = ctl_q.src_sw;
      bus_rdata[CTL_COMP] = ctl_q.comp;
    end
  end
endmodule

// File: rtl/tpo_active_reg.sv
module tpo_active_reg #(
  parameter int NPIN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] buf_q,
  input  logic [NPIN-1:0] wdata,
  input  logic            wr_buf,
  input  logic            halted,
  input  logic            cmp_match,
  input  logic            sw_strobe,
  input  logic            src_sw,
  output logic [NPIN-1:0] act_q
);
  logic            load_evt;
  logic            take;
  logic [NPIN-1:0] next_val;

  assign load_evt = src_sw ? sw_strobe : cmp_match;
  assign take     = load_evt || (wr_buf && halted);
  // A write in the same cycle wins over the stored buffer
  assign next_val = wr_buf ? wdata : buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (take) act_q <= next_val;
  end
endmodule

// File: rtl/tpo_pin_drive.sv
module tpo_pin_drive #(
  parameter int NPHASE = 3,
  localparam int NPIN = 2 * NPHASE
) (
  input  logic [NPIN-1:0] act_q,
  input  logic            comp,
  input  logic [NPIN-1:0] lvl_en,
  input  logic [NPIN-1:0] pwm_wave,
  output logic [NPIN-1:0] pin_o
);
  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    logic hi_lvl, lo_lvl;
    assign hi_lvl = act_q[2*p];
    assign lo_lvl = comp ? ~act_q[2*p] : act_q[2*p+1];
    assign pin_o[2*p]   = lvl_en[2*p]   ? hi_lvl : pwm_wave[2*p];
    assign pin_o[2*p+1] = lvl_en[2*p+1] ? lo_lvl : pwm_wave[2*p+1];
  end
endmodule

// File: rtl/tpo_level_reg.sv
module tpo_level_reg
  import tpo_pkg::*;
#(
  parameter int NPHASE = 3,
  parameter int DW     = 8,
  parameter int AW     = 2,
  localparam int NPIN  = 2 * NPHASE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            cmp_match_i,
  input  logic            cnt_halted_i,
  input  logic [NPIN-1:0] lvl_en_i,
  input  logic [NPIN-1:0] pwm_wave_i,
  output logic [NPIN-1:0] pin_o
);
  logic [NPIN-1:0] buf_q;
  logic [NPIN-1:0] act_q;
  ctl_t            ctl_q;
  logic            wr_buf, sw_strobe;
  logic            ctl_src, ctl_comp;

  assign ctl_src  = ctl_q.src_sw;
  assign ctl_comp = ctl_q.comp;

  tpo_bus_regs #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .buf_q(buf_q),
    .ctl_q(ctl_q), .wr_buf(wr_buf), .sw_strobe(sw_strobe)
  );

  tpo_active_reg #(.NPIN(NPIN)) u_act (
    .clk(clk), .rst_n(rst_n), .buf_q(buf_q), .wdata(bus_wdata[NPIN-1:0]),
    .wr_buf(wr_buf), .halted(cnt_halted_i), .cmp_match(cmp_match_i),
    .sw_strobe(sw_strobe), .src_sw(ctl_src), .act_q(act_q)
  );

  tpo_pin_drive #(.NPHASE(NPHASE)) u_drv (
    .act_q(act_q), .comp(ctl_comp), .lvl_en(lvl_en_i),
    .pwm_wave(pwm_wave_i), .pin_o(pin_o)
  );
endmodule

// File: rtl/tpo_level_sva.sv
module tpo_level_sva
  import tpo_pkg::*;
#(
  parameter int NPHASE = 3,
  parameter int DW     = 8,
  parameter int AW     = 2,
  localparam int NPIN  = 2 * NPHASE
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            cmp_match_i,
  input logic            cnt_halted_i,
  input logic [NPIN-1:0] lvl_en_i,
  input logic [NPIN-1:0] pin_o,
  input logic [NPIN-1:0] act_q,
  input logic [NPIN-1:0] buf_q,
  input logic            ctl_src,
  input logic            ctl_comp
);
  logic to_buf;
  assign to_buf = (bus_addr == AW'(ADDR_BUF));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !cmp_match_i) |=> $stable(act_q));

  p_cmp_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_src && cmp_match_i && !bus_wr) |=> act_q == $past(buf_q));

  p_sw_ignores_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_src && cmp_match_i && !bus_wr) |=> $stable(act_q));

  for (genvar p = 0; p < NPHASE; p++) begin : g_pair
    p_comp_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_comp && lvl_en_i[2*p] && lvl_en_i[2*p+1]) |-> (pin_o[2*p+1] == ~pin_o[2*p]));
  end

  p_halt_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && to_buf && cnt_halted_i) |=> act_q == $past(bus_wdata[NPIN-1:0]));

  p_top_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr && to_buf) && to_buf) |-> (&bus_rdata[DW-1:NPIN]));

  p_reset_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (act_q == '0 && buf_q == '0));

  p_new_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && to_buf && !ctl_src && cmp_match_i) |=> act_q == $past(bus_wdata[NPIN-1:0]));
endmodule

bind tpo_level_reg tpo_level_sva #(.NPHASE(NPHASE), .DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match_i(cmp_match_i),
  .cnt_halted_i(cnt_halted_i), .lvl_en_i(lvl_en_i), .pin_o(pin_o),
  .act_q(act_q), .buf_q(buf_q), .ctl_src(ctl_src), .ctl_comp(ctl_comp)
);

// File: tb/test_tpo_level_reg.sv
`timescale 1ns/100ps
module test_tpo_level_reg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       cmp_match_i = 0;
  logic       cnt_halted_i = 0;
  logic [5:0] lvl_en_i = 6'h3F;
  logic [5:0] pwm_wave_i = 0;
  logic [5:0] pin_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpo_level_reg i_tpo_level_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match_i(cmp_match_i),
    .cnt_halted_i(cnt_halted_i), .lvl_en_i(lvl_en_i), .pwm_wave_i(pwm_wave_i),
    .pin_o(pin_o)
  );

  // Behavioural reference
  bit [5:0] m_buf, m_act;
  bit       m_src, m_comp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_buf <= 0; m_act <= 0; m_src <= 0; m_comp <= 0;
    end else begin
      bit wb, wc, ld;
      wb = bus_wr && bus_addr == 0;
      wc = bus_wr && bus_addr == 1;
      ld = m_src ? (wc && bus_wdata[2]) : cmp_match_i;
      if ((wb && cnt_halted_i) || ld) m_act <= wb ? bus_wdata[5:0] : m_buf;
      if (wb) m_buf <= bus_wdata[5:0];
      if (wc) begin m_src <= bus_wdata[0]; m_comp <= bus_wdata[1]; end
    end
  end

  function automatic bit [5:0] exp_pins();
    bit [5:0] r;
    for (int p = 0; p < 3; p++) begin
      bit hi, lo;
      hi = m_act[2*p];
      lo = m_comp ? !m_act[2*p] : m_act[2*p+1];
      r[2*p]   = lvl_en_i[2*p]   ? hi : pwm_wave_i[2*p];
      r[2*p+1] = lvl_en_i[2*p+1] ? lo : pwm_wave_i[2*p+1];
    end
    return r;
  endfunction

  function automatic bit [7:0] exp_rd();
    if (bus_addr == 0) return {2'b11, m_buf};
    if (bus_addr == 1) return {6'b0, m_comp, m_src};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1/R5/R10 pins vs model", {2'b0, pin_o}, {2'b0, exp_pins()});
    chk("R7/R4 rdata vs model", bus_rdata, exp_rd());
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    bus_addr = a; #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_cmp();
    cmp_match_i = 1; tick(); cmp_match_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R8 reset state
    rd(0, 8'hC0, "R8 buffer reset");
    rd(1, 8'h00, "R8 control reset");
    chk("R8 pins low", {2'b0, pin_o}, 8'h00);

    // R7 and R2
    wr(0, 8'hFF);
    rd(0, 8'hFF, "R7 top bits read 1");
    wr(0, 8'h15);
    rd(0, 8'hD5, "R7 top write ignored");
    chk("R2 no load yet", {2'b0, pin_o}, 8'h00);

    // R3 and R1
    pulse_cmp();
    chk("R3 compare load", {2'b0, pin_o}, 8'h15);
    chk("R1 bit map U high", {7'b0, pin_o[0]}, 8'h01);

    // R4 software source
    wr(1, 8'h01);
    wr(0, 8'h2A);
    pulse_cmp();
    chk("R4 compare ignored", {2'b0, pin_o}, 8'h15);
    wr(1, 8'h05);
    chk("R4 software load", {2'b0, pin_o}, 8'h2A);
    rd(1, 8'h01, "R4 strobe reads 0");

    // R5 complementary mode
    wr(0, 8'h3F);
    wr(1, 8'h07);
    chk("R5 lower bits ignored", {2'b0, pin_o}, 8'h15);
    wr(0, 8'h05);
    wr(1, 8'h07);
    chk("R5 inversion pattern", {2'b0, pin_o}, 8'h25);

    // R6 write-through while halted
    wr(1, 8'h01);
    cnt_halted_i = 1;
    wr(0, 8'h33);
    chk("R6 write-through", {2'b0, pin_o}, 8'h33);
    rd(0, 8'hF3, "R6 buffer also written");
    cnt_halted_i = 0;

    // R9 write and compare load together
    wr(1, 8'h00);
    cmp_match_i = 1;
    wr(0, 8'h0C);
    cmp_match_i = 0;
    chk("R9 new value wins", {2'b0, pin_o}, 8'h0C);

    // R4 strobe ignored under compare select
    wr(0, 8'h01);
    wr(1, 8'h04);
    chk("R4 strobe ignored", {2'b0, pin_o}, 8'h0C);

    // R10 waveform pass-through
    lvl_en_i = 6'b000111;
    pwm_wave_i = 6'b101010;
    #0.5;
    chk("R10 pwm pass-through", {2'b0, pin_o}, 8'h2C);
    tick();
    pwm_wave_i = 6'b010101;
    #0.5;
    chk("R10 pwm follows", {2'b0, pin_o}, 8'h14);
    tick();

    finish_run();
  end
endmodule